// File: doc/BRIEF.md
# Circular Page Record Tracker

This block steers the recording of fixed-size pages into a circular region of external memory and keeps a live record of what that region holds. For every incoming framed page it supplies the page slot index and the memory word address to write to. It wraps back to slot 0 after the last slot. It keeps the slot index and timestamp of both the newest and the oldest page that is still valid in memory. One enable input governs recording for every antenna input of the device at once. A mode input selects full recording, where every antenna input is stored, or half recording, where only the even-indexed inputs are stored.

The mode sets the page size in memory words: 657 words when everything is recorded and 329 words when half is. The number of page slots is the memory size in bytes divided by the page size in bytes, rounded down. Each rising edge of the enable starts a fresh recording and latches the mode. Lowering the enable freezes the buffer at once, so the status outputs describe a stable snapshot that software can read out. The memory controller and the page framing sit outside this block. A page is offered with `page_valid` and its timestamp, and `wr_accept` tells the framing side whether that page was taken.

Top module: `page_ring_tracker`

## Requirements
- R1: After reset, `recording` and `wr_accept` are 0, and `wr_idx`, `wr_addr`, `first_idx`, `last_idx`, `first_ts` and `last_ts` are all 0.
- R2: A 0-to-1 transition of `rec_en` starts recording. From the next cycle `recording` is 1, and `wr_idx` and `wr_addr` are 0.
- R3: While `recording` is 1, `wr_accept` equals `page_valid` in the same cycle. One cycle after an accepted page, `last_idx` holds the slot that page was written to, `last_ts` holds its timestamp, and `wr_idx` points to the following slot.
- R4: `wr_addr` always equals `wr_idx` multiplied by `page_words`.
- R5: `page_words` is 657 when `rec_all` was 1 at the start of recording and 329 when it was 0. `page_count` is floor(MEM_BYTES / (page_words * BYTES_PER_WORD)). With the default parameters this gives 5 and 10 slots. Before any start, the full-recording values apply.
- R6: After a page is written to slot `page_count`-1, `wr_idx` and `wr_addr` return to 0.
- R7: `first_idx` stays 0 until every slot has been written once. After that, each accepted page sets it to `last_idx`+1, wrapping to 0. `first_ts` is the timestamp of the first page of the recording until that page is overwritten. After that it is the timestamp of the page at `first_idx`, which is `last_ts` minus (`page_count`-1) times TS_STEP.
- R8: When `rec_en` is 0, `recording` and `wr_accept` are 0 in that same cycle, and `page_valid` has no effect. The index and timestamp outputs keep their values.
- R9: Every new start clears `first_idx`, `last_idx`, `first_ts`, `last_ts` and the wrapped state, whatever the buffer held before.
- R10: Changing `rec_all` while recording does not change `page_words`, `page_count` or the address sequence until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_en | input | 1 | Record enable for all antenna inputs; a rising edge starts, low freezes |
| rec_all | input | 1 | 1 = record all inputs, 0 = even-indexed inputs only; latched at start |
| page_valid | input | 1 | A framed page is offered for writing this cycle |
| page_ts | input | TS_W | Timestamp (sample sequence number) of the offered page |
| wr_accept | output | 1 | Offered page is taken and written to `wr_addr` |
| wr_idx | output | IDX_W | Slot index for the next page |
| wr_addr | output | ADDR_W | Memory word address of slot `wr_idx` |
| recording | output | 1 | Recording is active |
| page_words | output | WPW_W | Memory words per page in the latched mode |
| page_count | output | IDX_W | Number of page slots in the latched mode |
| first_idx | output | IDX_W | Slot of the oldest valid page |
| first_ts | output | TS_W | Timestamp of the oldest valid page |
| last_idx | output | IDX_W | Slot of the newest page |
| last_ts | output | TS_W | Timestamp of the newest page |

## Verification
The oldest-page timestamp is derived, not stored. It is therefore only correct if, within one recording, every accepted page carries a timestamp exactly TS_STEP above the one before it. One assertion checks that assumption at the input. The bench keeps to it by generating timestamps from a running counter that advances by TS_STEP for each accepted page and restarts from a new base on each start. Mode changes, freezes and restarts are applied only on falling clock edges with `page_valid` low, except for the freeze case, which deliberately offers a page in the same cycle that the enable drops.

// File: rtl/page_ring_tracker.sv
module page_ring_tracker #(
  parameter int MEM_BYTES      = 211200,
  parameter int BYTES_PER_WORD = 64,
  parameter int WORDS_ALL      = 657,
  parameter int WORDS_HALF     = 329,
  parameter int TS_W           = 64,
  parameter int TS_STEP        = 4672,
  localparam int PAGES_ALL  = MEM_BYTES / (WORDS_ALL * BYTES_PER_WORD),
  localparam int PAGES_HALF = MEM_BYTES / (WORDS_HALF * BYTES_PER_WORD),
  localparam int IDX_W      = $clog2(PAGES_HALF + 1),
  localparam int ADDR_W     = $clog2(MEM_BYTES / BYTES_PER_WORD),
  localparam int WPW_W      = $clog2(WORDS_ALL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_en,
  input  logic              rec_all,
  input  logic              page_valid,
  input  logic [TS_W-1:0]   page_ts,
  output logic              wr_accept,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              recording,
  output logic [WPW_W-1:0]  page_words,
  output logic [IDX_W-1:0]  page_count,
  output logic [IDX_W-1:0]  first_idx,
  output logic [TS_W-1:0]   first_ts,
  output logic [IDX_W-1:0]  last_idx,
  output logic [TS_W-1:0]   last_ts
);

  logic              en_q;
  logic              mode_q;
  logic              full_q;
  logic              any_q;
  logic [IDX_W-1:0]  next_idx;
  logic [ADDR_W-1:0] next_addr;
  logic              start;
  logic              at_end;

  assign start      = rec_en & ~en_q;
  assign recording  = rec_en & en_q;
  assign wr_accept  = page_valid & recording;
  assign page_words = mode_q ? WPW_W'(WORDS_ALL) : WPW_W'(WORDS_HALF);
  assign page_count = mode_q ? IDX_W'(PAGES_ALL) : IDX_W'(PAGES_HALF);
  assign at_end     = (next_idx == page_count - 1'b1);
  assign wr_idx     = next_idx;
  assign wr_addr    = next_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mode_q    <= 1'b1;
      full_q    <= 1'b0;
      any_q     <= 1'b0;
      next_idx  <= '0;
      next_addr <= '0;
      first_idx <= '0;
      last_idx  <= '0;
      first_ts  <= '0;
      last_ts   <= '0;
    end else begin
      en_q <= rec_en;
      if (start) begin
        mode_q    <= rec_all;
        full_q    <= 1'b0;
        any_q     <= 1'b0;
        next_idx  <= '0;
        next_addr <= '0;
        first_idx <= '0;
        last_idx  <= '0;
        first_ts  <= '0;
        last_ts   <= '0;
      end else if (wr_accept) begin
        last_idx <= next_idx;
        last_ts  <= page_ts;
        any_q    <= 1'b1;
        if (!any_q) first_ts <= page_ts;
        if (at_end) begin
          next_idx  <= '0;
          next_addr <= '0;
        end else begin
          next_idx  <= next_idx + 1'b1;
          next_addr <= next_addr + ADDR_W'(page_words);
        end
        if (full_q) begin
          first_idx <= at_end ? '0 : next_idx + 1'b1;
          first_ts  <= first_ts + TS_W'(TS_STEP);
        end else if (at_end) begin
          full_q <= 1'b1;
        end
      end
    end
  end

  p_accept_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> (rec_en && en_q));

  p_addr_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_addr) == int'(wr_idx) * int'(page_words));

  p_idx_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx < page_count);

  p_last_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !start) |=> (last_idx == $past(wr_idx)) && (last_ts == $past(page_ts)));

  p_first_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> first_idx == ((last_idx == page_count - 1'b1) ? '0 : last_idx + 1'b1));

  p_ts_contiguous_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && any_q) |-> page_ts == last_ts + TS_W'(TS_STEP));

  p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |=> $stable(last_idx) && $stable(last_ts) && $stable(first_idx) && $stable(wr_idx));

  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_en && en_q) |=> $stable(page_words));

endmodule

// File: tb/page_ring_tracker_bench.sv
module page_ring_tracker_bench;
  localparam int TS_W = 64;
  localparam int STEP = 4672;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rec_en, rec_all, page_valid;
  logic [TS_W-1:0] page_ts;
  logic            wr_accept, recording;
  logic [3:0]      wr_idx, page_count, first_idx, last_idx;
  logic [11:0]     wr_addr;
  logic [9:0]      page_words;
  logic [TS_W-1:0] first_ts, last_ts;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_next, m_first, m_last, m_cnt, m_words;
  bit m_full, m_any;
  longint m_first_ts, m_last_ts, cur_ts;

  page_ring_tracker u_page_ring_tracker (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .rec_all(rec_all),
    .page_valid(page_valid), .page_ts(page_ts), .wr_accept(wr_accept),
    .wr_idx(wr_idx), .wr_addr(wr_addr), .recording(recording),
    .page_words(page_words), .page_count(page_count), .first_idx(first_idx),
    .first_ts(first_ts), .last_idx(last_idx), .last_ts(last_ts)
  );

  always #10 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_status(string req);
    check({req, " wr_idx"}, wr_idx, m_next);
    check({req, " wr_addr"}, wr_addr, m_next * m_words);
    check({req, " last_idx"}, last_idx, m_last);
    check({req, " last_ts"}, last_ts, m_last_ts);
    check({req, " first_idx"}, first_idx, m_first);
    check({req, " first_ts"}, first_ts, m_first_ts);
  endtask

  task automatic t_reset();
    rst_n = 0; rec_en = 0; rec_all = 0; page_valid = 0; page_ts = '0;
    repeat (3) @(negedge clk);
    check("R1 recording", recording, 0);
    check("R1 wr_accept", wr_accept, 0);
    m_next = 0; m_first = 0; m_last = 0; m_first_ts = 0; m_last_ts = 0; m_words = 657;
    check_status("R1");
    rst_n = 1;
    @(negedge clk);
    check("R5 default page_words", page_words, 657);
  endtask

  task automatic t_start(bit all, longint base);
    rec_en = 0; page_valid = 0;
    @(negedge clk);
    rec_en = 1; rec_all = all;
    @(negedge clk);
    m_next = 0; m_first = 0; m_last = 0; m_first_ts = 0; m_last_ts = 0;
    m_full = 0; m_any = 0; cur_ts = base;
    m_words = all ? 657 : 329;
    m_cnt   = all ? 5 : 10;
    check("R2 recording", recording, 1);
    check("R5 page_words", page_words, m_words);
    check("R5 page_count", page_count, m_cnt);
    check_status("R2 R9 cleared");
  endtask

  task automatic t_pages(int n, string req);
    for (int i = 0; i < n; i++) begin
      page_valid = 1; page_ts = cur_ts;
      #1;
      check({req, " R3 wr_accept"}, wr_accept, 1);
      check({req, " R4 addr"}, wr_addr, m_next * m_words);
      @(negedge clk);
      page_valid = 0;
      m_last = m_next; m_last_ts = cur_ts;
      if (!m_any) m_first_ts = cur_ts;
      m_any = 1;
      if (m_full) begin
        m_first = (m_next == m_cnt - 1) ? 0 : m_next + 1;
        m_first_ts = cur_ts - longint'(m_cnt - 1) * STEP;
      end else if (m_next == m_cnt - 1) m_full = 1;
      m_next = (m_next == m_cnt - 1) ? 0 : m_next + 1;
      cur_ts += STEP;
      check_status({req, " R3 R6 R7"});
    end
  endtask

  task automatic t_freeze();
    @(negedge clk);
    rec_en = 0; page_valid = 1; page_ts = cur_ts;
    #1;
    check("R8 recording low", recording, 0);
    check("R8 wr_accept low", wr_accept, 0);
    repeat (3) @(negedge clk);
    check("R8 recording still low", recording, 0);
    check_status("R8 held");
    page_valid = 0;
  endtask

  task automatic t_mode_change();
    rec_all = ~rec_all;
    @(negedge clk);
    check("R10 page_words", page_words, m_words);
    check("R10 page_count", page_count, m_cnt);
    t_pages(3, "R10");
  endtask

  initial begin
    t_reset();
    t_start(1, 1000);
    t_pages(3, "all");
    t_pages(6, "all wrap");
    t_freeze();
    t_start(0, 77000);
    check("R9 first_idx", first_idx, 0);
    t_pages(4, "half");
    t_mode_change();
    t_pages(6, "half wrap");
    t_freeze();
    t_start(1, 5);
    t_pages(5, "all fill");
    check("R6 wrap idx", wr_idx, 0);
    check("R6 wrap addr", wr_addr, 0);
    check("R7 first_idx full", first_idx, 0);
    t_pages(1, "all over");
    check("R7 first advanced", first_idx, 1);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule